// File: doc/BRIEF.md
# Parallel Write Strobe Qualifier

This block sits behind the pins of a parallel memory port. It samples the active-low chip-select, write-strobe and read-enable inputs with a fast system clock. It turns each legal write cycle on those pins into exactly one single-cycle write event.

A write cycle is the interval in which chip-select and write-strobe are both low and read-enable is high. The address is taken when that interval opens, which is the moment the later of the two selects falls. The data is the value on the data pins in the last sampled cycle before the interval closes, which is the moment the earlier select rises. An interval seen for fewer than `MIN_W` clock cycles is treated as a glitch and thrown away.

The controls pass through a two-flop synchroniser. The address and data buses go through a matching two-stage delay, so that all of them stay aligned. The state machine has four states:
- `ST_IDLE`: no strobe.
- `ST_ARMED`: a strobe is open but shorter than `MIN_W`.
- `ST_HELD`: a strobe is open and has reached `MIN_W`.
- `ST_EMIT`: the cycle that carries the write pulse.

The transitions are:
- IDLE/EMIT→ARMED on a strobe start, or IDLE/EMIT→HELD when `MIN_W` is 1.
- ARMED→ARMED while the strobe is still short.
- ARMED→HELD when the count reaches `MIN_W`.
- ARMED→IDLE on an early end, which aborts the cycle and clears the captured address.
- HELD→EMIT when the strobe ends.
- EMIT→IDLE when no new strobe is present.

Top module: `wstrobe_qual`

## Requirements
- R1: After reset `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: A write can only be produced while `ce_n`=0, `we_n`=0 and `oe_n`=1. A cycle with `oe_n` held low, or with only one of `ce_n`/`we_n` low, produces no pulse.
- R3: `wr_addr` is the address present when the combined strobe becomes active, that is, when the later of `ce_n`/`we_n` falls. Address changes after that point are ignored.
- R4: `wr_data` is the data present in the last cycle the strobe was active, that is, just before the earlier of `ce_n`/`we_n` rises. Data after the strobe closes is ignored.
- R5: A strobe sampled active for fewer than `MIN_W` cycles produces no pulse. A strobe of exactly `MIN_W` cycles produces one pulse.
- R6: Each qualified strobe gives exactly one `wr_valid` pulse, one cycle wide. The pulse is seen 3 clock edges after the strobe ends at the pins: 2 for synchronisation and 1 for the state machine.
- R7: While `wr_valid` is 0, `wr_addr` and `wr_data` are zero.
- R8: A rejected short strobe discards its address. The next qualified write reports its own address.
- R9: `oe_n` falling during a write closes the strobe. The data reported is the value from before that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low (must be high to write) |
| addr_in | input | ADDR_W | Address pins |
| data_in | input | DATA_W | Data pins |
| wr_valid | output | 1 | One-cycle write event |
| wr_addr | output | ADDR_W | Captured address, zero when not valid |
| wr_data | output | DATA_W | Captured data, zero when not valid |

## Verification
Suppose the state machine is left in ARMED or HELD when it should not be. The next strobe's pulse then appears at the wrong time, or an extra pulse appears, within three cycles of the strobe edge. A bad width counter shows up as a glitch that is passed through or a legal write that is dropped. A stale address register shows up as the wrong `wr_addr` on the very next pulse. Any data captured outside the active window changes `wr_data` on the pulse that closes that strobe.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HELD,
        ST_EMIT
    } wsq_state_e;
endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg[i] <= RST_VAL;
                else if (i == 0)
                    stg[i] <= d;
                else
                    stg[i] <= stg[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wsq_fsm.sv
module wsq_fsm
    import wsq_pkg::*;
#(
    parameter int MIN_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    output logic       start,
    output logic       abort,
    output logic       fire,
    output wsq_state_e state
);
    localparam int CW = $clog2(MIN_W + 1);

    wsq_state_e nxt;
    logic [CW-1:0] cnt;
    logic          reached;

    assign reached = (int'(cnt) + 1) >= MIN_W;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_EMIT: begin
                if (strobe) nxt = (MIN_W <= 1) ? ST_HELD : ST_ARMED;
                else        nxt = ST_IDLE;
            end
            ST_ARMED: begin
                if (!strobe)      nxt = ST_IDLE;
                else if (reached) nxt = ST_HELD;
                else              nxt = ST_ARMED;
            end
            ST_HELD: nxt = strobe ? ST_HELD : ST_EMIT;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE || state == ST_EMIT)
                cnt <= CW'(1);
            else if (state == ST_ARMED && strobe && !reached)
                cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        start = (state == ST_IDLE || state == ST_EMIT) && strobe;
        abort = (state == ST_ARMED) && !strobe;
        fire  = (state == ST_EMIT);
    end
endmodule

// File: rtl/wstrobe_qual.sv
module wstrobe_qual
    import wsq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int MIN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [2:0]        ctl_s;
    logic [BUS_W-1:0]  bus_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] data_d;
    logic              strobe_s;
    logic              start, abort, fire;
    wsq_state_e        state;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    wsq_sync #(.W(3), .STAGES(2), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s)
    );

    wsq_sync #(.W(BUS_W), .STAGES(2), .RST_VAL('0)) u_bus_dly (
        .clk(clk), .rst_n(rst_n), .d({addr_in, data_in}), .q(bus_d)
    );

    assign {addr_d, data_d} = bus_d;
    assign strobe_s = !ctl_s[2] && !ctl_s[1] && ctl_s[0];

    wsq_fsm #(.MIN_W(MIN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(strobe_s),
        .start(start), .abort(abort), .fire(fire), .state(state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            if (start)      cap_addr <= addr_d;
            else if (abort) cap_addr <= '0;
            if (strobe_s)   cap_data <= data_d;
        end
    end

    always_comb begin
        wr_valid = fire;
        wr_addr  = fire ? cap_addr : '0;
        wr_data  = fire ? cap_data : '0;
    end
endmodule

// File: rtl/wstrobe_qual_chk.sv
module wstrobe_qual_chk
    import wsq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int MIN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_s,
    input wsq_state_e        state,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    logic        prev_s;
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_s  <= 1'b0;
            run_len <= 0;
        end else begin
            prev_s <= strobe_s;
            if (strobe_s && !prev_s) run_len <= 1;
            else if (strobe_s && run_len < 1000) run_len <= run_len + 1;
        end
    end

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r6_after_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (!$past(strobe_s) && $past(strobe_s, 2)));

    a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> run_len >= MIN_W);

    a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (wr_addr == '0 && wr_data == '0));

    a_r2_no_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_s |=> (state != ST_ARMED && state != ST_HELD));
endmodule

bind wstrobe_qual wstrobe_qual_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_W(MIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .state(state),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/wstrobe_qual_tb_top.sv
`timescale 1ns/1ps
module wstrobe_qual_tb_top;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int MIN_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [ADDR_W+DATA_W-1:0] exp_q [$];

    always #10 clk = ~clk;

    wstrobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_W(MIN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr_in(addr_in), .data_in(data_in),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        exp_q.push_back({a, d});
    endtask

    // simple write with both selects moving together
    task automatic plain_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int len);
        addr_in = a; data_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        if (len >= MIN_W) expect_wr(a, d);
        cyc(len);
        ce_n = 1'b1; we_n = 1'b1; addr_in = ~a; data_in = ~d;
        cyc(1);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R5 unexpected pulse", {7'd0, wr_addr, wr_data}, 32'd0);
                end else begin
                    logic [ADDR_W+DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(wr_addr == e[ADDR_W+DATA_W-1:DATA_W], "R3 wr_addr", 32'(wr_addr), 32'(e[ADDR_W+DATA_W-1:DATA_W]));
                    check(wr_data == e[DATA_W-1:0], "R4 wr_data", 32'(wr_data), 32'(e[DATA_W-1:0]));
                end
            end else if (wr_addr != '0 || wr_data != '0) begin
                check(1'b0, "R7 outputs not zero when idle", {7'd0, wr_addr, wr_data}, 32'd0);
            end
        end
    end

    initial begin
        fork
            begin
                cyc(3);
                check(wr_valid == 1'b0 && wr_addr == '0 && wr_data == '0, "R1 reset state",
                      {6'd0, wr_valid, wr_addr, wr_data}, 32'd0);
                rst_n = 1'b1;
                cyc(3);

                // R6 latency: pulse visible at third negedge after strobe end
                addr_in = 17'h01234; data_in = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
                expect_wr(17'h01234, 8'h5A);
                cyc(5);
                ce_n = 1'b1; we_n = 1'b1; addr_in = '0; data_in = '0;
                cyc(2);
                check(wr_valid == 1'b0, "R6 pulse not early", 32'(wr_valid), 32'd0);
                cyc(1);
                check(wr_valid == 1'b1, "R6 pulse at third edge", 32'(wr_valid), 32'd1);
                cyc(1);
                check(wr_valid == 1'b0, "R6 pulse one cycle wide", 32'(wr_valid), 32'd0);
                cyc(3);

                // R3 later fall / R4 earlier rise
                addr_in = 17'h00AAA; data_in = 8'h11; ce_n = 1'b0;
                cyc(2);
                addr_in = 17'h01555;
                cyc(1);
                we_n = 1'b0;
                cyc(1);
                addr_in = 17'h01FFF;
                cyc(2);
                data_in = 8'h22;
                cyc(2);
                ce_n = 1'b1; data_in = 8'h33;
                cyc(1);
                we_n = 1'b1;
                expect_wr(17'h01555, 8'h22);
                cyc(6);

                // R5 glitch rejection and R8 address discard
                plain_write(17'h00F0F, 8'hC3, MIN_W - 1);
                cyc(5);
                check(exp_q.size() == 0, "R5 short strobe queued nothing", 32'(exp_q.size()), 32'd0);
                addr_in = 17'h00101; data_in = 8'h3C; ce_n = 1'b0;
                cyc(1);
                we_n = 1'b0;
                expect_wr(17'h00101, 8'h3C);
                cyc(MIN_W);
                we_n = 1'b1; ce_n = 1'b1;
                cyc(6);

                // R2 suppression cases
                oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; addr_in = 17'h00077; data_in = 8'h99;
                cyc(6);
                ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
                cyc(2);
                we_n = 1'b0;
                cyc(6);
                we_n = 1'b1; ce_n = 1'b0;
                cyc(6);
                ce_n = 1'b1;
                cyc(6);

                // R9 read enable falling mid-write
                addr_in = 17'h10000; data_in = 8'h77; ce_n = 1'b0; we_n = 1'b0;
                cyc(4);
                oe_n = 1'b0; data_in = 8'h88;
                cyc(2);
                ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
                expect_wr(17'h10000, 8'h77);
                cyc(6);

                // R6 back-to-back writes
                plain_write(17'h00002, 8'hA5, MIN_W);
                plain_write(17'h1FFFF, 8'h00, MIN_W + 2);
                cyc(6);

                // R2/R3/R4 sweep of patterns
                for (int k = 0; k < 12; k++) begin
                    plain_write(17'((k * 4099 + 13) & 17'h1FFFF), 8'(k * 37 + 1), MIN_W + (k % 4));
                    cyc(k % 3);
                end
                cyc(10);
                check(exp_q.size() == 0, "R6 every qualified strobe pulsed", 32'(exp_q.size()), 32'd0);
            end
            begin
                cyc(20000);
                check(1'b0, "watchdog expired", 32'd0, 32'd1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule